// File: doc/BRIEF.md
# I2C Command Word Sequencer

This block turns a stream of 10-bit command words into the start, byte-write, byte-read and stop operations of a byte-level I2C master engine. Software writes command words into a 16-entry transmit queue through a small register port. Bit 8 of a word asks for a start (or repeated start) ahead of its byte, and bit 9 asks for a stop after it. A word carrying bit 8 is an address byte whose bit 0 selects the direction. After a read address, the next queued word is a byte count rather than bus data.

Received bytes land in a 16-entry receive queue with a zero-based watermark. The block raises level events for transmit empty, transmit half empty and receive at watermark. It raises one-cycle pulses for a transfer error (address or data NACK, or a completed read) and for the bus going idle after a stop. The bit-level SCL/SDA engine is outside the block. It is reached through a request/done handshake that returns an acknowledge bit and read data.

Register map (reg_addr): 0 control (bit 0 enable, bit 1 transmit-queue clear), 1 status, 2 transmit word (write pushes), 3 receive byte (read pops), 4 transmit occupancy, 5 receive occupancy, 6 receive watermark (4 bits). Engine operation codes: 0 start, 1 write byte, 2 read byte, 3 stop.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A word at the queue head with bit 8 set produces a start operation, then a write of its low byte; bit 0 of that byte is the direction, 1 read, 0 write.
- R2: A word without bit 8 is written as a data byte; bit 9 on any acknowledged write word produces a stop after it.
- R3: An address word with bits 8 and 9 both set produces start, address write, stop and nothing else.
- R4: After an acknowledged read address, the next word is consumed without a bus operation; its low byte gives the number of reads, the last read carries eng_nack=1, and its bit 9 requests a stop after the last byte.
- R5: evt_tx_err pulses for one cycle after a NACKed write operation and after the final read of a read command.
- R6: After a NACK, the queued words are discarded up to and including the next word with bit 9 set, and a stop is issued.
- R7: Both queues hold 16 entries; the occupancy registers read entry count minus one, and 0 when empty.
- R8: A push into a full transmit queue is dropped; a pop from an empty receive queue returns 0; neither changes occupancy.
- R9: The watermark resets to 15; evt_rx_full is high while the receive queue holds at least watermark+1 bytes.
- R10: evt_tx_half is high while the transmit queue holds 8 or fewer words; evt_tx_empty is high while it holds none.
- R11: No engine operation starts while control bit 0 is clear; while control bit 1 is set the transmit queue stays empty and pushes are lost.
- R12: The status byte has bit 2 bus busy, bit 4 transmit queue full, bit 5 receive queue full, bit 6 receive queue empty, bit 7 transmit queue empty, all other bits 0.
- R13: Bus busy rises when a start completes and falls when a stop completes; evt_bus_idle pulses once at that fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 3) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| evt_tx_empty | output | 1 | Transmit queue empty (level) |
| evt_tx_half | output | 1 | Transmit queue at or below half (level) |
| evt_rx_full | output | 1 | Receive queue at watermark (level) |
| evt_tx_err | output | 1 | NACK or read completion (pulse) |
| evt_bus_idle | output | 1 | Bus returned idle after stop (pulse) |
| eng_req | output | 1 | Engine operation request, held until done |
| eng_op | output | 2 | Engine operation code |
| eng_byte | output | 8 | Byte to write |
| eng_nack | output | 1 | Read operation should NACK this byte |
| eng_done | input | 1 | Engine operation complete (pulse) |
| eng_ack | input | 1 | Acknowledge seen on a write |
| eng_rdata | input | 8 | Byte received by a read |

## Verification
On every cycle, the assertions check several properties. A request and its operation code stay stable until the engine answers. Bus busy rises only after a completed start, and the idle pulse follows only a busy bus. An error pulse always traces back to a NACKed write or a final read. Queue counts never pass the depth, and they do not move on an overflowing push or an empty pop. Only the bench's scenarios can show the decoded operation order. Those scenarios cover address-only writes, repeated starts, reads with a consumed count word, and the discard after a NACK. They also show the exact occupancy and flag values across every fill level, and the data popped back out of the receive queue.

// File: rtl/i2c_cmd_pkg.sv
// Shared widths and engine operation codes for the I2C command sequencer.
package i2c_cmd_pkg;
    localparam int WORD_W = 10;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_t;
endpackage

// File: rtl/i2c_cmd_fifo.sv
// Synchronous queue with head peek. Assumes push and pop are single-cycle
// strobes; an overflowing push is dropped and an empty queue shows 0 at head.
module i2c_cmd_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign do_push = push && (int'(count) < DEPTH) && !clr;
    assign do_pop  = pop && (count != '0) && !clr;
    assign head    = (count == '0) ? '0 : mem[rd_ptr];

    // Storage write on accepted push.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (int'(wr_ptr) == DEPTH-1) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (int'(rd_ptr) == DEPTH-1) ? '0 : rd_ptr + 1'b1;
            count <= count + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop && !clr && int'(count) == DEPTH |=> int'(count) == DEPTH);
    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !push && !clr && count == '0 |=> count == '0);
endmodule

// File: rtl/i2c_cmd_decoder.sv
// Walks the command queue and drives the engine handshake, one operation at
// a time. Assumes the engine holds eng_done for one cycle per accepted request.
module i2c_cmd_decoder
    import i2c_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [WORD_W-1:0] tx_head,
    input  logic              tx_empty,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_wdata,
    output logic              tx_err,
    output logic              bus_idle_evt,
    output logic              bus_busy,
    output logic              eng_req,
    output eng_op_t           eng_op,
    output logic [BYTE_W-1:0] eng_byte,
    output logic              eng_nack,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [BYTE_W-1:0] eng_rdata
);
    typedef enum logic [2:0] {
        S_IDLE, S_START, S_ADDR, S_DATA, S_CNT, S_READ, S_FLUSH, S_STOP
    } state_t;

    state_t            state;
    logic [BYTE_W-1:0] remaining;
    logic              stop_after;

    // Engine request decode from the current state.
    always_comb begin
        eng_req  = 1'b0;
        eng_op   = OP_START;
        eng_byte = '0;
        eng_nack = 1'b0;
        case (state)
            S_START: eng_req = 1'b1;
            S_ADDR, S_DATA: begin
                eng_req  = 1'b1;
                eng_op   = OP_WRITE;
                eng_byte = tx_head[BYTE_W-1:0];
            end
            S_READ: begin
                eng_req  = 1'b1;
                eng_op   = OP_READ;
                eng_nack = (remaining == 8'd1);
            end
            S_STOP: begin
                eng_req = 1'b1;
                eng_op  = OP_STOP;
            end
            default: ;
        endcase
    end

    // Queue pops: after a write completes, on the count word, during discard.
    always_comb begin
        tx_pop = 1'b0;
        case (state)
            S_ADDR, S_DATA: tx_pop = eng_done;
            S_CNT, S_FLUSH: tx_pop = !tx_empty;
            default: ;
        endcase
    end

    assign rx_push  = (state == S_READ) && eng_done;
    assign rx_wdata = eng_rdata;

    // Sequencer state, counters and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            remaining    <= '0;
            stop_after   <= 1'b0;
            tx_err       <= 1'b0;
            bus_idle_evt <= 1'b0;
            bus_busy     <= 1'b0;
        end else begin
            tx_err       <= 1'b0;
            bus_idle_evt <= 1'b0;
            case (state)
                S_IDLE:
                    if (enable && !tx_empty) state <= tx_head[8] ? S_START : S_DATA;
                S_START:
                    if (eng_done) begin
                        bus_busy <= 1'b1;
                        state    <= S_ADDR;
                    end
                S_ADDR, S_DATA:
                    if (eng_done) begin
                        if (!eng_ack) begin
                            tx_err <= 1'b1;
                            state  <= tx_head[9] ? S_STOP : S_FLUSH;
                        end else if (state == S_ADDR && tx_head[0]) begin
                            state <= S_CNT;
                        end else begin
                            state <= tx_head[9] ? S_STOP : S_IDLE;
                        end
                    end
                S_CNT:
                    if (!tx_empty) begin
                        remaining  <= tx_head[BYTE_W-1:0];
                        stop_after <= tx_head[9];
                        if (tx_head[BYTE_W-1:0] == '0)
                            state <= tx_head[9] ? S_STOP : S_IDLE;
                        else
                            state <= S_READ;
                    end
                S_READ:
                    if (eng_done) begin
                        remaining <= remaining - 1'b1;
                        if (remaining == 8'd1) begin
                            tx_err <= 1'b1;
                            state  <= stop_after ? S_STOP : S_IDLE;
                        end
                    end
                S_FLUSH:
                    if (!tx_empty && tx_head[9]) state <= S_STOP;
                S_STOP:
                    if (eng_done) begin
                        bus_busy     <= 1'b0;
                        bus_idle_evt <= 1'b1;
                        state        <= S_IDLE;
                    end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_byte));
    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> $past(eng_done && ((eng_op == OP_WRITE && !eng_ack) ||
                                      (eng_op == OP_READ && eng_nack))));
    p_busy_rise_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_busy) |-> $past(eng_done && eng_op == OP_START));
    p_idle_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle_evt |-> !bus_busy && $past(bus_busy));
endmodule

// File: rtl/i2c_cmd_seq.sv
// Top level: register port, transmit and receive queues, status and events.
// Assumes reg_wr and reg_rd are single-cycle strobes from one bus master.
module i2c_cmd_seq
    import i2c_cmd_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [9:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    output logic        evt_tx_empty,
    output logic        evt_tx_half,
    output logic        evt_rx_full,
    output logic        evt_tx_err,
    output logic        evt_bus_idle,
    output logic        eng_req,
    output logic [1:0]  eng_op,
    output logic [7:0]  eng_byte,
    output logic        eng_nack,
    input  logic        eng_done,
    input  logic        eng_ack,
    input  logic [7:0]  eng_rdata
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] WM_RESET = AW'(DEPTH - 1);

    logic [1:0]        ctrl;
    logic [AW-1:0]     watermark;
    logic [WORD_W-1:0] tx_head;
    logic [WORD_W-1:0] rx_head_w;
    logic [AW:0]       tx_count, rx_count;
    logic              tx_pop, rx_push, bus_busy;
    logic [BYTE_W-1:0] rx_wdata;
    logic              tx_push, rx_pop;
    eng_op_t           op_enum;
    logic [7:0]        status;
    logic [AW-1:0]     tx_occ, rx_occ;

    assign tx_push = reg_wr && reg_addr == 3'd2;
    assign rx_pop  = reg_rd && reg_addr == 3'd3;

    // Control and watermark registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            watermark <= WM_RESET;
        end else if (reg_wr) begin
            if (reg_addr == 3'd0) ctrl      <= reg_wdata[1:0];
            if (reg_addr == 3'd6) watermark <= reg_wdata[AW-1:0];
        end
    end

    i2c_cmd_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_tx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(ctrl[1]),
        .push(tx_push), .wdata(reg_wdata), .pop(tx_pop),
        .head(tx_head), .count(tx_count)
    );

    i2c_cmd_fifo #(.W(WORD_W), .DEPTH(DEPTH)) i_rx_fifo (
        .clk(clk), .rst_n(rst_n), .clr(1'b0),
        .push(rx_push), .wdata({2'b00, rx_wdata}), .pop(rx_pop),
        .head(rx_head_w), .count(rx_count)
    );

    i2c_cmd_decoder i_decoder (
        .clk(clk), .rst_n(rst_n), .enable(ctrl[0]),
        .tx_head(tx_head), .tx_empty(tx_count == '0), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_wdata(rx_wdata),
        .tx_err(evt_tx_err), .bus_idle_evt(evt_bus_idle), .bus_busy(bus_busy),
        .eng_req(eng_req), .eng_op(op_enum), .eng_byte(eng_byte),
        .eng_nack(eng_nack), .eng_done(eng_done), .eng_ack(eng_ack),
        .eng_rdata(eng_rdata)
    );
    assign eng_op = op_enum;

    assign tx_occ = (tx_count == '0) ? '0 : AW'(tx_count - 1'b1);
    assign rx_occ = (rx_count == '0) ? '0 : AW'(rx_count - 1'b1);

    assign status = {tx_count == '0, rx_count == '0, int'(rx_count) == DEPTH,
                     int'(tx_count) == DEPTH, 1'b0, bus_busy, 2'b00};

    assign evt_tx_empty = (tx_count == '0);
    assign evt_tx_half  = (int'(tx_count) <= DEPTH / 2);
    assign evt_rx_full  = (rx_count > {1'b0, watermark});

    // Register read mux.
    always_comb begin
        case (reg_addr)
            3'd0:    reg_rdata = {6'b0, ctrl};
            3'd1:    reg_rdata = status;
            3'd3:    reg_rdata = rx_head_w[7:0];
            3'd4:    reg_rdata = 8'(tx_occ);
            3'd5:    reg_rdata = 8'(rx_occ);
            3'd6:    reg_rdata = 8'(watermark);
            default: reg_rdata = 8'h00;
        endcase
    end

    p_no_op_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] && !eng_req |=> !eng_req);
    p_clear_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl[1] |=> tx_count == '0);
endmodule

// File: tb/test_i2c_cmd_seq.sv
`timescale 1ns/1ps
module test_i2c_cmd_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [9:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       evt_tx_empty, evt_tx_half, evt_rx_full, evt_tx_err, evt_bus_idle;
    logic       eng_req, eng_nack;
    logic [1:0] eng_op;
    logic [7:0] eng_byte;
    logic       eng_done, eng_ack;
    logic [7:0] eng_rdata;

    int tests = 0, fails = 0;
    int err_cnt = 0, idle_cnt = 0;
    int busy_cnt = 0, rd_idx = 0, log_n = 0;
    logic [10:0] log_e [128];
    logic [10:0] exp_e [32];
    int exp_n;

    always #4 clk = ~clk;

    i2c_cmd_seq i_i2c_cmd_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_tx_empty(evt_tx_empty), .evt_tx_half(evt_tx_half),
        .evt_rx_full(evt_rx_full), .evt_tx_err(evt_tx_err),
        .evt_bus_idle(evt_bus_idle), .eng_req(eng_req), .eng_op(eng_op),
        .eng_byte(eng_byte), .eng_nack(eng_nack), .eng_done(eng_done),
        .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    // Engine model: answers each request after a few cycles; address 0x58 NACKs.
    always @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt <= 0; eng_done <= 1'b0; eng_ack <= 1'b0; eng_rdata <= '0;
        end else begin
            eng_done <= 1'b0;
            if (busy_cnt != 0) begin
                busy_cnt <= busy_cnt - 1;
                if (busy_cnt == 1) begin
                    eng_done <= 1'b1;
                    eng_ack  <= !(eng_op == 2'd1 && eng_byte[7:1] == 7'h58);
                    if (eng_op == 2'd2) begin
                        eng_rdata <= 8'h80 + 8'(rd_idx);
                        rd_idx    <= rd_idx + 1;
                    end
                    log_e[log_n] <= {eng_op, eng_nack, eng_byte};
                    log_n <= log_n + 1;
                end
            end else if (eng_req && !eng_done) begin
                busy_cnt <= 2;
            end
        end
    end

    // Event pulse counters.
    always @(posedge clk) begin
        if (rst_n && evt_tx_err)   err_cnt  <= err_cnt + 1;
        if (rst_n && evt_bus_idle) idle_cnt <= idle_cnt + 1;
    end

    // Watchdog.
    initial begin
        #1000000;
        fails = fails + 1;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [9:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic pop_rx(output logic [7:0] d);
        @(negedge clk); reg_addr = 3'd3; #1 d = reg_rdata; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ex(input logic [1:0] op, input logic nk, input logic [7:0] b);
        exp_e[exp_n] = {op, nk, b}; exp_n = exp_n + 1;
    endtask

    task automatic cmp_ops(input string req, input int from);
        check({req, " op count"}, log_n - from, exp_n);
        for (int i = 0; i < exp_n && i < log_n - from; i++)
            check({req, " op"}, int'(log_e[from + i]), int'(exp_e[i]));
    endtask

    initial begin
        logic [7:0] v;
        int base, e0, i0, cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R12, R9, R7).
        rd(3'd1, v); check("R12 reset status", v, 8'hC0);
        rd(3'd6, v); check("R9 watermark reset", v, 15);
        rd(3'd4, v); check("R7 tx occupancy empty", v, 0);
        check("R10 empty level at reset", evt_tx_empty, 1);

        // Fill sweep with device disabled (R7, R8, R10, R11, R12).
        for (int k = 1; k <= 17; k++) begin
            wr(3'd2, 10'h011);
            cnt = (k > 16) ? 16 : k;
            rd(3'd4, v); check("R7 R8 tx occupancy", v, cnt - 1);
            check("R10 half level", evt_tx_half, (cnt <= 8) ? 1 : 0);
            check("R10 empty level", evt_tx_empty, 0);
            rd(3'd1, v); check("R12 full bit", v[4], (cnt == 16) ? 1 : 0);
        end
        check("R11 no op while disabled", log_n, 0);
        wr(3'd0, 10'h002);
        rd(3'd1, v); check("R11 R12 clear empties queue", v, 8'hC0);
        wr(3'd2, 10'h011);
        rd(3'd4, v); check("R11 push lost during clear", v, 0);
        check("R11 push lost empty flag", evt_tx_empty, 1);
        wr(3'd0, 10'h001);

        // Write with data and stop (R1, R2, R13).
        base = log_n; i0 = idle_cnt; e0 = err_cnt;
        wr(3'd2, 10'h1A0); wr(3'd2, 10'h011); wr(3'd2, 10'h222);
        idle(80);
        exp_n = 0; ex(0,0,0); ex(1,0,8'hA0); ex(1,0,8'h11); ex(1,0,8'h22); ex(3,0,0);
        cmp_ops("R1 R2 write", base);
        check("R13 idle pulse", idle_cnt - i0, 1);
        check("R5 no error on ack", err_cnt - e0, 0);
        rd(3'd1, v); check("R13 bus free after stop", v[2], 0);

        // Address-only write (R3).
        base = log_n;
        wr(3'd2, 10'h3A0); idle(60);
        exp_n = 0; ex(0,0,0); ex(1,0,8'hA0); ex(3,0,0);
        cmp_ops("R3 address only", base);

        // NACK on address discards through the stop word (R5, R6).
        base = log_n; e0 = err_cnt;
        wr(3'd2, 10'h1B0); wr(3'd2, 10'h033); wr(3'd2, 10'h244);
        idle(60);
        exp_n = 0; ex(0,0,0); ex(1,0,8'hB0); ex(3,0,0);
        cmp_ops("R6 nack discard", base);
        check("R5 nack error pulse", err_cnt - e0, 1);
        rd(3'd4, v); check("R6 queue drained", evt_tx_empty, 1);

        // Read of three bytes with watermark 2 (R4, R5, R9).
        wr(3'd6, 10'h002);
        base = log_n; e0 = err_cnt;
        wr(3'd2, 10'h1A1); wr(3'd2, 10'h203);
        idle(80);
        exp_n = 0; ex(0,0,0); ex(1,0,8'hA1); ex(2,0,0); ex(2,0,0); ex(2,1,0); ex(3,0,0);
        cmp_ops("R4 read", base);
        check("R5 read completion error", err_cnt - e0, 1);
        check("R9 rx at watermark", evt_rx_full, 1);
        rd(3'd5, v); check("R7 rx occupancy", v, 2);
        pop_rx(v); check("R4 rx byte0", v, 8'h80);
        check("R9 below watermark", evt_rx_full, 0);
        pop_rx(v); check("R4 rx byte1", v, 8'h81);
        pop_rx(v); check("R4 rx byte2", v, 8'h82);
        pop_rx(v); check("R8 empty pop zero", v, 0);
        rd(3'd5, v); check("R8 rx occupancy unchanged", v, 0);
        rd(3'd1, v); check("R12 rx empty bit", v, 8'hC0);

        // Repeated start: write then one-byte read with stop (R1, R4, R13).
        base = log_n; i0 = idle_cnt;
        wr(3'd2, 10'h1A0); wr(3'd2, 10'h055); wr(3'd2, 10'h1A1); wr(3'd2, 10'h201);
        idle(100);
        exp_n = 0; ex(0,0,0); ex(1,0,8'hA0); ex(1,0,8'h55);
        ex(0,0,0); ex(1,0,8'hA1); ex(2,1,0); ex(3,0,0);
        cmp_ops("R1 R4 repeated start", base);
        check("R13 single idle pulse", idle_cnt - i0, 1);
        pop_rx(v); check("R4 repeated read byte", v, 8'h83);

        // Read without stop keeps the bus busy (R13).
        wr(3'd2, 10'h1A1); wr(3'd2, 10'h001); idle(60);
        rd(3'd1, v); check("R13 busy held without stop", v[2], 1);
        wr(3'd2, 10'h3A0); idle(60);
        rd(3'd1, v); check("R13 busy cleared", v[2], 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule